// File: doc/BRIEF.md
# Overflow-Aware Adaptive Dot-Product Conversion Controller

This block sequences one signed dot product of ten elements held in a compute-in-memory array. Each element pairs a 2-bit unsigned input, applied as a word-line pulse lasting that many cycles, with a signed weight from -4 to +4. The charge the accessed element removes from the bit-lines is represented by a behavioural partial-sum register. The controller precharges the bit-lines and visits the elements strictly in index order. After every access it checks whether one more worst-case product could push the partial sum outside the span of the 6-bit converter. When that could happen, it halts the access sequence, runs a six-step successive-approximation conversion and recharges the bit-lines before going on.

The 6-bit chunks are summed in a digital accumulator. One last conversion of the residual charge completes an exact 8-bit signed result. A mode input chooses between the vertical strobes, used for inference, and the horizontal strobes, used for the transposed product during learning. The arithmetic is the same in both modes. When a sequence finishes, the block reports the result, a one-cycle done strobe and the number of conversions that ran.

Top module: `mac_conv_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, all strobes and the converter enable are low, and the result and conversion count read zero.
- R2: A start pulse is taken only while idle. A start pulse during a sequence has no effect on that sequence's result, conversion count or strobes.
- R3: After the access of any element other than the last, a conversion begins when the partial sum is above 19 or below -20. Otherwise the next element is accessed directly. As a result the partial sum always stays within -32..31.
- R4: The result equals the exact integer dot product, sum of x_i*w_i, as an 8-bit two's-complement value. The inputs are packed as x_i at bits [2i+1:2i] of x_vec_i and w_i as 4-bit two's complement at bits [4i+3:4i] of w_vec_i.
- R5: The conversion count equals the number of mid-sequence conversions under the R3 rule plus one for the final conversion.
- R6: Each sequence begins with exactly one precharge cycle, and each mid-sequence conversion is followed by exactly one recharge cycle. The precharge strobe is therefore high for a number of cycles equal to the conversion count.
- R7: Elements are accessed in order 0 to 9, and the word line of element i is high for exactly x_i cycles. At most one word line is high at a time.
- R8: With mode_i=0 only the vertical word-line and precharge strobes are used. With mode_i=1 only the horizontal ones are used. The strobes of the other direction stay low for the whole sequence.
- R9: busy_o is high for 1 + sum(max(x_i,1)) + 10 + 7*C - 1 cycles, where C is the conversion count. It is then followed by exactly one cycle of done_o.
- R10: adc_en_o is high for exactly 6 cycles per conversion, and never in a cycle in which a word line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 selects vertical (inference) strobes, 1 selects horizontal (transposed) strobes |
| x_vec_i | input | 20 | Ten 2-bit unsigned inputs |
| w_vec_i | input | 40 | Ten 4-bit signed weights |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 8 | Signed dot product |
| conv_cnt_o | output | 4 | Conversions run in the last sequence |
| wl_v_o | output | 10 | Vertical word-line pulses |
| wl_h_o | output | 10 | Horizontal word-line pulses |
| pre_v_o | output | 1 | Vertical bit-line precharge/recharge |
| pre_h_o | output | 1 | Horizontal bit-line precharge/recharge |
| adc_en_o | output | 1 | Converter active |

## Verification
The overflow check and the end of the sequence meet when the last element's access drives the partial sum past the threshold. In that case only the single final conversion may run, with no recharge and no extra conversion. The bench provokes this by sweeping every input and weight value at element 9, and at every other position, on a fixed background. It judges the outcome by comparing the conversion count, the precharge-cycle count and the busy length with values derived arithmetically from the threshold rule. A second clash, a start pulse arriving in the middle of a sequence together with changed operands, is judged by the result and the conversion count of the original operands.

// File: rtl/mac_conv_pkg.sv
package mac_conv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_ACC,
        PH_CHK,
        PH_CONV,
        PH_RECH,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/mac_operand_bank.sv
module mac_operand_bank #(
    parameter int N_ELEM = 10,
    parameter int X_W    = 2,
    parameter int W_W    = 4,
    localparam int IDX_W = $clog2(N_ELEM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [N_ELEM*X_W-1:0]   x_in,
    input  logic [N_ELEM*W_W-1:0]   w_in,
    input  logic [IDX_W-1:0]        sel,
    output logic [X_W-1:0]          x_sel,
    output logic signed [W_W-1:0]   w_sel
);

    typedef struct packed {
        logic [N_ELEM*X_W-1:0] x;
        logic [N_ELEM*W_W-1:0] w;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.x = x_in;
            b_d.w = w_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    logic [X_W-1:0] x_arr [N_ELEM];
    logic [W_W-1:0] w_arr [N_ELEM];

    for (genvar g = 0; g < N_ELEM; g++) begin : g_unpack
        assign x_arr[g] = b_q.x[g*X_W +: X_W];
        assign w_arr[g] = b_q.w[g*W_W +: W_W];
    end

    always_comb begin
        x_sel = '0;
        w_sel = '0;
        if (32'(sel) < N_ELEM) begin
            x_sel = x_arr[sel];
            w_sel = $signed(w_arr[sel]);
        end
    end

endmodule

// File: rtl/mac_charge_model.sv
module mac_charge_model #(
    parameter int W_W    = 4,
    parameter int PS_W   = 7,
    parameter int LO_LIM = -32,
    parameter int HI_LIM = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   add_en,
    input  logic signed [W_W-1:0]  w_sel,
    output logic signed [PS_W-1:0] psum
);

    logic signed [PS_W-1:0] psum_d, psum_q;
    logic signed [PS_W-1:0] w_ext;

    assign w_ext = {{(PS_W-W_W){w_sel[W_W-1]}}, w_sel};

    always_comb begin
        psum_d = psum_q;
        if (clear)       psum_d = '0;
        else if (add_en) psum_d = psum_q + w_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psum_q <= '0;
        else        psum_q <= psum_d;
    end

    assign psum = psum_q;

    // R3: the modelled bit-line charge never leaves the converter span
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psum_q >= PS_W'(LO_LIM)) && (psum_q <= PS_W'(HI_LIM)));

endmodule

// File: rtl/mac_sar_model.sv
module mac_sar_model #(
    parameter int CHUNK_W = 6,
    localparam int BIT_W  = $clog2(CHUNK_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic signed [CHUNK_W-1:0] sample,
    output logic                      busy_o,
    output logic                      last_o,
    output logic signed [CHUNK_W-1:0] value_o
);

    localparam logic [CHUNK_W-1:0] MSB = CHUNK_W'(1) << (CHUNK_W-1);

    typedef struct packed {
        logic               busy;
        logic [BIT_W-1:0]   bitn;
        logic [CHUNK_W-1:0] u;
        logic [CHUNK_W-1:0] code;
        logic [CHUNK_W-1:0] smp;
    } sar_t;

    sar_t s_d, s_q;
    logic [CHUNK_W-1:0] trial, code_n;

    always_comb begin
        trial  = s_q.code | (CHUNK_W'(1) << s_q.bitn);
        code_n = (s_q.u >= trial) ? trial : s_q.code;
        s_d    = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.bitn = BIT_W'(CHUNK_W-1);
            s_d.u    = sample ^ MSB;
            s_d.code = '0;
            s_d.smp  = sample;
        end else if (s_q.busy) begin
            s_d.code = code_n;
            if (s_q.bitn == '0) s_d.busy = 1'b0;
            else                s_d.bitn = s_q.bitn - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = s_q.busy;
    assign last_o  = s_q.busy && (s_q.bitn == '0);
    assign value_o = $signed(code_n ^ MSB);

    // R4: the binary search lands on the sampled charge
    assert_sar_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (value_o == $signed(s_q.smp)));

endmodule

// File: rtl/mac_conv_ctrl.sv
module mac_conv_ctrl
    import mac_conv_pkg::*;
#(
    parameter int N_ELEM  = 10,
    parameter int X_W     = 2,
    parameter int W_W     = 4,
    parameter int W_MAG   = 4,
    parameter int CHUNK_W = 6,
    parameter int RES_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       mode_i,
    input  logic [N_ELEM*X_W-1:0]      x_vec_i,
    input  logic [N_ELEM*W_W-1:0]      w_vec_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic signed [RES_W-1:0]    result_o,
    output logic [$clog2(N_ELEM+1)-1:0] conv_cnt_o,
    output logic [N_ELEM-1:0]          wl_v_o,
    output logic [N_ELEM-1:0]          wl_h_o,
    output logic                       pre_v_o,
    output logic                       pre_h_o,
    output logic                       adc_en_o
);

    localparam int IDX_W     = $clog2(N_ELEM);
    localparam int CNT_W     = $clog2(N_ELEM+1);
    localparam int PS_W      = CHUNK_W + 1;
    localparam int CHUNK_MAX = (2**(CHUNK_W-1)) - 1;
    localparam int CHUNK_MIN = -(2**(CHUNK_W-1));
    localparam int MAX_PROD  = ((2**X_W) - 1) * W_MAG;
    localparam int HI_LIM    = CHUNK_MAX - MAX_PROD;
    localparam int LO_LIM    = CHUNK_MIN + MAX_PROD;

    typedef struct packed {
        phase_e                  ph;
        logic [IDX_W-1:0]        idx;
        logic [X_W-1:0]          pc;
        logic                    fin;
        logic                    mode;
        logic signed [RES_W-1:0] acc;
        logic signed [RES_W-1:0] res;
        logic [CNT_W-1:0]        cnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                      load, chg_clear, add_en, sar_start;
    logic [X_W-1:0]            x_sel;
    logic signed [W_W-1:0]     w_sel;
    logic signed [PS_W-1:0]    psum;
    logic                      sar_busy, sar_last;
    logic signed [CHUNK_W-1:0] sar_val;
    logic [X_W:0]              x_len;
    logic                      pulse_on, over;
    logic signed [RES_W-1:0]   val_ext;

    mac_operand_bank #(.N_ELEM(N_ELEM), .X_W(X_W), .W_W(W_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .x_in  (x_vec_i),
        .w_in  (w_vec_i),
        .sel   (c_q.idx),
        .x_sel (x_sel),
        .w_sel (w_sel)
    );

    mac_charge_model #(.W_W(W_W), .PS_W(PS_W), .LO_LIM(CHUNK_MIN), .HI_LIM(CHUNK_MAX)) u_charge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (chg_clear),
        .add_en (add_en),
        .w_sel  (w_sel),
        .psum   (psum)
    );

    mac_sar_model #(.CHUNK_W(CHUNK_W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sar_start),
        .sample  (psum[CHUNK_W-1:0]),
        .busy_o  (sar_busy),
        .last_o  (sar_last),
        .value_o (sar_val)
    );

    assign x_len    = (x_sel == '0) ? (X_W+1)'(1) : {1'b0, x_sel};
    assign pulse_on = (c_q.ph == PH_ACC) && (c_q.pc < x_sel);
    assign over     = (psum > PS_W'(HI_LIM)) || (psum < PS_W'(LO_LIM));
    assign val_ext  = {{(RES_W-CHUNK_W){sar_val[CHUNK_W-1]}}, sar_val};

    always_comb begin
        c_d       = c_q;
        load      = 1'b0;
        chg_clear = 1'b0;
        add_en    = 1'b0;
        sar_start = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    load     = 1'b1;
                    c_d.mode = mode_i;
                    c_d.acc  = '0;
                    c_d.cnt  = '0;
                    c_d.idx  = '0;
                    c_d.pc   = '0;
                    c_d.fin  = 1'b0;
                    c_d.ph   = PH_PRE;
                end
            end
            PH_PRE: begin
                chg_clear = 1'b1;
                c_d.ph    = PH_ACC;
            end
            PH_ACC: begin
                add_en = pulse_on;
                if (({1'b0, c_q.pc} + 1'b1) >= x_len) begin
                    c_d.pc = '0;
                    c_d.ph = PH_CHK;
                end else begin
                    c_d.pc = c_q.pc + 1'b1;
                end
            end
            PH_CHK: begin
                if (c_q.idx == IDX_W'(N_ELEM-1)) begin
                    c_d.fin   = 1'b1;
                    sar_start = 1'b1;
                    c_d.ph    = PH_CONV;
                end else if (over) begin
                    c_d.fin   = 1'b0;
                    sar_start = 1'b1;
                    c_d.ph    = PH_CONV;
                end else begin
                    c_d.idx = c_q.idx + 1'b1;
                    c_d.ph  = PH_ACC;
                end
            end
            PH_CONV: begin
                if (sar_last) begin
                    c_d.acc = c_q.acc + val_ext;
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (c_q.fin) begin
                        c_d.res = c_q.acc + val_ext;
                        c_d.ph  = PH_DONE;
                    end else begin
                        c_d.ph  = PH_RECH;
                    end
                end
            end
            PH_RECH: begin
                chg_clear = 1'b1;
                c_d.idx   = c_q.idx + 1'b1;
                c_d.ph    = PH_ACC;
            end
            PH_DONE: begin
                c_d.ph = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic [N_ELEM-1:0] wl_sel;
    logic              pre_any;

    assign wl_sel     = pulse_on ? (N_ELEM'(1) << c_q.idx) : '0;
    assign pre_any    = (c_q.ph == PH_PRE) || (c_q.ph == PH_RECH);
    assign wl_v_o     = c_q.mode ? '0 : wl_sel;
    assign wl_h_o     = c_q.mode ? wl_sel : '0;
    assign pre_v_o    = pre_any && !c_q.mode;
    assign pre_h_o    = pre_any && c_q.mode;
    assign adc_en_o   = (c_q.ph == PH_CONV);
    assign busy_o     = (c_q.ph != PH_IDLE) && (c_q.ph != PH_DONE);
    assign done_o     = (c_q.ph == PH_DONE);
    assign result_o   = c_q.res;
    assign conv_cnt_o = c_q.cnt;

    // R10: converter activity and word-line access are exclusive
    assert_adc_no_wl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_en_o |-> ((wl_v_o | wl_h_o) == '0));

    // R10: the search engine runs exactly while the FSM is converting
    assert_sar_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sar_busy == adc_en_o);

    // R7: never more than one word line
    assert_one_wl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wl_v_o, wl_h_o}));

    // R8: direction exclusivity
    assert_mode_vert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !c_q.mode) |-> (wl_h_o == '0 && !pre_h_o));
    assert_mode_horz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && c_q.mode) |-> (wl_v_o == '0 && !pre_v_o));

    // R6: a sequence opens with a precharge cycle
    assert_pre_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (pre_v_o || pre_h_o));

    // R9: done is a single-cycle strobe
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: conversion count bounded by element count
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(conv_cnt_o) <= N_ELEM);

endmodule

// File: tb/mac_conv_ctrl_tb.sv
module mac_conv_ctrl_tb;

    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [19:0] x_vec_i = '0;
    logic [39:0] w_vec_i = '0;
    logic        busy_o, done_o, pre_v_o, pre_h_o, adc_en_o;
    logic signed [7:0] result_o;
    logic [3:0]  conv_cnt_o;
    logic [9:0]  wl_v_o, wl_h_o;

    mac_conv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .x_vec_i(x_vec_i), .w_vec_i(w_vec_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .conv_cnt_o(conv_cnt_o), .wl_v_o(wl_v_o),
        .wl_h_o(wl_h_o), .pre_v_o(pre_v_o), .pre_h_o(pre_h_o), .adc_en_o(adc_en_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int xs [N];
    int ws [N];
    bit [31:0] rng = 32'h1234_5679;

    // monitor counters
    int wl_cnt [N];
    int busy_cyc, adc_cyc, pre_cyc, wrong_dir, order_err, overlap, done_cnt, last_idx;
    bit cur_mode;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++)
                if (wl_v_o[i] || wl_h_o[i]) begin
                    wl_cnt[i]++;
                    if (i < last_idx) order_err++;
                    last_idx = i;
                end
            if (busy_o) busy_cyc++;
            if (adc_en_o) adc_cyc++;
            if (pre_v_o || pre_h_o) pre_cyc++;
            if (!cur_mode && (wl_h_o != 0 || pre_h_o)) wrong_dir++;
            if (cur_mode && (wl_v_o != 0 || pre_v_o)) wrong_dir++;
            if (adc_en_o && (wl_v_o | wl_h_o) != 0) overlap++;
            if (done_o) done_cnt++;
        end
    end

    function automatic bit [31:0] nxt(input bit [31:0] s);
        bit [31:0] t = s;
        t ^= t << 13;
        t ^= t >> 17;
        t ^= t << 5;
        return t;
    endfunction

    task automatic run_case(input bit md, input bit inject);
        int dot = 0, ps = 0, nconv = 0, len = 0, exp_busy, wait_n;
        for (int i = 0; i < N; i++) begin
            dot += xs[i] * ws[i];
            len += (xs[i] == 0) ? 1 : xs[i];
            ps  += xs[i] * ws[i];
            if (i < N-1 && (ps > 19 || ps < -20)) begin
                nconv++;
                ps = 0;
            end
        end
        nconv++;
        exp_busy = 1 + len + N + 7*nconv - 1;

        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            x_vec_i[i*2 +: 2] = 2'(xs[i]);
            w_vec_i[i*4 +: 4] = 4'(ws[i]);
            wl_cnt[i] = 0;
        end
        mode_i = md;
        cur_mode = md;
        busy_cyc = 0; adc_cyc = 0; pre_cyc = 0; wrong_dir = 0;
        order_err = 0; overlap = 0; done_cnt = 0; last_idx = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_n = 0;
        while (!done_o && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
            if (inject && wait_n == 4) begin
                x_vec_i = ~x_vec_i;
                w_vec_i = 40'h1111111111;
                mode_i  = ~md;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk("R9 done seen", int'(done_o), 1);
        @(negedge clk);
        chk("R4 result", int'(result_o), dot);
        chk("R5/R3 conversion count", int'(conv_cnt_o), nconv);
        chk("R9 busy length", busy_cyc, exp_busy);
        chk("R9 done pulses", done_cnt, 1);
        chk("R10 adc cycles", adc_cyc, 6*nconv);
        chk("R10 adc/wl overlap", overlap, 0);
        chk("R6 precharge cycles", pre_cyc, nconv);
        chk("R8 wrong direction strobes", wrong_dir, 0);
        chk("R7 access order", order_err, 0);
        for (int i = 0; i < N; i++) chk($sformatf("R7 wl cycles elem %0d", i), wl_cnt[i], xs[i]);
        if (inject) chk("R2 busy after ignored start", int'(busy_o), 0);
    endtask

    task automatic set_base();
        int bx [N] = '{1,2,3,0,1,2,3,1,2,0};
        int bw [N] = '{2,-3,4,-1,0,3,-4,1,-2,4};
        for (int i = 0; i < N; i++) begin
            xs[i] = bx[i];
            ws[i] = bw[i];
        end
    endtask

    initial begin
        cur_mode = 1'b0;
        for (int i = 0; i < N; i++) wl_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 result", int'(result_o), 0);
        chk("R1 conv count", int'(conv_cnt_o), 0);
        chk("R1 strobes", int'({wl_v_o, wl_h_o, pre_v_o, pre_h_o, adc_en_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // extremes, both directions (R4, R8)
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < N; i++) begin xs[i] = 3; ws[i] = 4; end
            run_case(1'(m), 1'b0);
            for (int i = 0; i < N; i++) begin xs[i] = 3; ws[i] = -4; end
            run_case(1'(m), 1'b0);
            for (int i = 0; i < N; i++) begin xs[i] = 0; ws[i] = 4; end
            run_case(1'(m), 1'b0);
            for (int i = 0; i < N; i++) begin xs[i] = 3; ws[i] = (i % 2) ? -4 : 4; end
            run_case(1'(m), 1'b0);
        end

        // R3 threshold edges: partial sum lands on 19, 20, -20, -21
        set_base();
        xs = '{3,1,1,0,0,0,0,0,0,0}; ws = '{4,4,3,0,0,0,0,0,0,0}; run_case(1'b0, 1'b0);
        xs = '{3,1,1,0,0,0,0,0,0,0}; ws = '{4,4,4,0,0,0,0,0,0,0}; run_case(1'b0, 1'b0);
        xs = '{3,2,0,0,0,0,0,0,0,0}; ws = '{-4,-4,0,0,0,0,0,0,0,0}; run_case(1'b1, 1'b0);
        xs = '{3,3,0,0,0,0,0,0,0,0}; ws = '{-4,-3,0,0,0,0,0,0,0,0}; run_case(1'b1, 1'b0);

        // sweep every value at every position on a fixed background
        for (int p = 0; p < N; p++)
            for (int xv = 0; xv < 4; xv++)
                for (int wv = -4; wv <= 4; wv++) begin
                    set_base();
                    for (int i = 0; i < N; i++) ws[i] = ws[i] * ((p % 2) ? 1 : -1);
                    for (int i = 0; i < p; i++) if (xs[i] != 0) xs[i] = 3;
                    xs[p] = xv;
                    ws[p] = wv;
                    run_case(1'(p % 2), 1'b0);
                end

        // pseudo-random operands
        for (int r = 0; r < 300; r++) begin
            for (int i = 0; i < N; i++) begin
                rng = nxt(rng);
                xs[i] = int'(rng[1:0]);
                ws[i] = int'(rng[7:4] % 9) - 4;
            end
            run_case(1'(r % 2), 1'b0);
        end

        // R2: start pulse and operand change during a sequence
        set_base();
        run_case(1'b0, 1'b1);
        for (int i = 0; i < N; i++) begin xs[i] = 3; ws[i] = -4; end
        run_case(1'b1, 1'b1);

        finish_run();
    end

endmodule